// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block forms the result of an add, subtract or bitwise operation on two operands and derives the condition flags of that result, in the style of the status word of a 16-bit processor. A width select chooses between a byte operation and a word operation. Every flag then follows that width: the carry, sign, zero and overflow bits are taken at bit 7 or at bit 15. Parity always looks at the low byte of the result. A separate nibble carry reports the carry or borrow across the bit 3/bit 4 boundary.

The result leaves the block combinationally. The condition flags are captured into a status register on a clock edge when the update enable is high. The same register holds three software-written control bits: single-step trap, interrupt enable and string direction. These bits are loaded only through their write strobe, and arithmetic never changes them. The whole status is presented as one 16-bit flag word with fixed bit positions.

Top module: `sff_status_unit`

## Requirements
- R1: `op_sel` selects the operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 pass `opnd_b`. In byte mode (`byte_mode`=1) only the low 8 bits of the operands are used, and `result[15:8]` is zero.
- R2: The carry flag (flag word bit 0) is the carry out of bit 7 (byte) or bit 15 (word) for additions, and the borrow for subtractions. Operations 4 to 7 clear it.
- R3: The parity flag (bit 2) is 1 when `result[7:0]` holds an even number of ones, in both widths.
- R4: The nibble carry flag (bit 4) is set on a carry out of bit 3 for additions, or on a borrow into bit 3 for subtractions. Operations 4 to 7 clear it.
- R5: The zero flag (bit 6) is set when the result at the selected width is all zeros. The sign flag (bit 7) copies bit 7 (byte) or bit 15 (word) of the result.
- R6: The overflow flag (bit 11) is set when the exact signed value of the arithmetic operation, carry or borrow included, falls outside the signed range of the selected width. Operations 4 to 7 clear it.
- R7: `carry_in` takes part only in operations 1 and 3. For every other operation it has no effect on the result or the flags.
- R8: The condition flags load on a rising clock edge only while `upd_en` is 1. Otherwise they hold their value.
- R9: With `ctl_wr`=1 a clock edge loads `ctl_wdata[0]` into trap (bit 8), `ctl_wdata[1]` into interrupt enable (bit 9) and `ctl_wdata[2]` into direction (bit 10). Flag updates never change these bits.
- R10: Bit 1 of the flag word reads 1. Bits 3, 5 and 15:12 read 0. After reset the flag word is 16'h0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| opnd_a | input | 16 | First operand (minuend) |
| opnd_b | input | 16 | Second operand (subtrahend) |
| carry_in | input | 1 | Carry/borrow input for operations 1 and 3 |
| upd_en | input | 1 | Capture condition flags on this edge |
| ctl_wr | input | 1 | Load control bits on this edge |
| ctl_wdata | input | 3 | New control bits {direction, interrupt enable, trap} |
| result | output | 16 | Operation result |
| flag_word | output | 16 | Packed status word |

## Verification
The hardest case to reach is overflow in a subtract with borrow whose operands sit at the signed boundary. An example is 0 minus 0x7F minus 1 in byte mode: the result is exactly the most negative value and must not be reported as overflow, while nearby operand pairs do overflow. The stimulus sweeps sets of operand values that always include 0, the largest positive, the most negative and all ones. Every pair is taken under every operation code, both carry-in values and both widths, so every boundary pair meets the borrow path. A directed sequence interleaves control writes with flag updates and held cycles, to show that the two halves of the status register never disturb each other.

// File: rtl/sff_pkg.sv
package sff_pkg;

  localparam int FLAG_W = 16;
  localparam int PAR_W  = 8;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_PASS = 3'd7
  } op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } arith_flags_t;

  typedef struct packed {
    logic dir;
    logic ien;
    logic trap;
  } ctl_flags_t;

  localparam int POS_CRY  = 0;
  localparam int POS_ONE  = 1;
  localparam int POS_PAR  = 2;
  localparam int POS_AUX  = 4;
  localparam int POS_ZER  = 6;
  localparam int POS_SGN  = 7;
  localparam int POS_TRAP = 8;
  localparam int POS_IEN  = 9;
  localparam int POS_DIR  = 10;
  localparam int POS_OVF  = 11;

  function automatic logic [FLAG_W-1:0] pack_flags(input arith_flags_t af,
                                                   input ctl_flags_t   cf);
    logic [FLAG_W-1:0] w;
    w           = '0;
    w[POS_ONE]  = 1'b1;
    w[POS_CRY]  = af.cry;
    w[POS_PAR]  = af.par;
    w[POS_AUX]  = af.aux;
    w[POS_ZER]  = af.zer;
    w[POS_SGN]  = af.sgn;
    w[POS_OVF]  = af.ovf;
    w[POS_TRAP] = cf.trap;
    w[POS_IEN]  = cf.ien;
    w[POS_DIR]  = cf.dir;
    return w;
  endfunction

endpackage

// File: rtl/sff_rst_sync.sv
module sff_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sff_lane_adder.sv
module sff_lane_adder #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_bx,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W/LANE_W-1:0] lane_carry
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANES:0] chain;
  assign chain[0] = cin;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W:0] part;
    assign part = {1'b0, opnd_a[g*LANE_W +: LANE_W]}
                + {1'b0, opnd_bx[g*LANE_W +: LANE_W]}
                + {{LANE_W{1'b0}}, chain[g]};
    assign sum[g*LANE_W +: LANE_W] = part[LANE_W-1:0];
    assign chain[g+1]              = part[LANE_W];
  end

  assign lane_carry = chain[LANES:1];
endmodule

// File: rtl/sff_flag_eval.sv
module sff_flag_eval
  import sff_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  op_e               op,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] sum,
  input  logic [DATA_W/LANE_W-1:0] lane_carry,
  output logic [DATA_W-1:0] result,
  output arith_flags_t      flags
);
  localparam int LANES  = DATA_W / LANE_W;
  localparam int NMSB   = LANE_W - 1;
  localparam int WMSB   = DATA_W - 1;
  localparam int UPPER  = DATA_W - LANE_W;

  logic              is_logic;
  logic              is_sub;
  logic [DATA_W-1:0] lres;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] bx;
  logic              cout;
  logic              cin_msb;

  always_comb begin
    is_logic = op[2];
    is_sub   = (op == OP_SUB) || (op == OP_SBB);
    bx       = is_sub ? ~opnd_b : opnd_b;
    unique case (op)
      OP_AND:  lres = opnd_a & opnd_b;
      OP_OR:   lres = opnd_a | opnd_b;
      OP_XOR:  lres = opnd_a ^ opnd_b;
      default: lres = opnd_b;
    endcase
    raw    = is_logic ? lres : sum;
    result = byte_mode ? {{UPPER{1'b0}}, raw[LANE_W-1:0]} : raw;

    if (byte_mode) begin
      cout    = lane_carry[0];
      cin_msb = opnd_a[NMSB] ^ bx[NMSB] ^ sum[NMSB];
    end else begin
      cout    = lane_carry[LANES-1];
      cin_msb = opnd_a[WMSB] ^ bx[WMSB] ^ sum[WMSB];
    end

    flags.cry = is_logic ? 1'b0 : (cout ^ is_sub);
    flags.ovf = is_logic ? 1'b0 : (cout ^ cin_msb);
    flags.aux = is_logic ? 1'b0 : (opnd_a[4] ^ opnd_b[4] ^ sum[4]);
    flags.par = ~^result[PAR_W-1:0];
    flags.zer = byte_mode ? (result[LANE_W-1:0] == '0) : (result == '0);
    flags.sgn = byte_mode ? result[NMSB] : result[WMSB];
  end
endmodule

// File: rtl/sff_flag_store.sv
module sff_flag_store
  import sff_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  arith_flags_t arith_in,
  input  logic         ctl_wr,
  input  ctl_flags_t   ctl_in,
  output arith_flags_t arith_q,
  output ctl_flags_t   ctl_q
);
  arith_flags_t arith_d;
  ctl_flags_t   ctl_d;

  always_comb begin
    arith_d = arith_q;
    if (upd_en) arith_d = arith_in;
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = ctl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arith_q <= '0;
      ctl_q   <= '0;
    end else begin
      arith_q <= arith_d;
      ctl_q   <= ctl_d;
    end
  end
endmodule

// File: rtl/sff_status_unit.sv
module sff_status_unit
  import sff_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_sel,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  input  logic              upd_en,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  output logic [DATA_W-1:0] result,
  output logic [15:0]       flag_word
);
  localparam int LANES = DATA_W / LANE_W;

  logic              rst_sync_n;
  op_e               op;
  logic              cin_eff;
  logic [DATA_W-1:0] bx;
  logic [DATA_W-1:0] sum;
  logic [LANES-1:0]  lane_carry;
  arith_flags_t      flags_next;
  arith_flags_t      flags_q;
  ctl_flags_t        ctl_q;

  sff_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    op = op_e'(op_sel);
    unique case (op)
      OP_ADC:  cin_eff = carry_in;
      OP_SUB:  cin_eff = 1'b1;
      OP_SBB:  cin_eff = ~carry_in;
      default: cin_eff = 1'b0;
    endcase
    bx = ((op == OP_SUB) || (op == OP_SBB)) ? ~opnd_b : opnd_b;
  end

  sff_lane_adder #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_adder (
    .opnd_a     (opnd_a),
    .opnd_bx    (bx),
    .cin        (cin_eff),
    .sum        (sum),
    .lane_carry (lane_carry)
  );

  sff_flag_eval #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_eval (
    .op         (op),
    .byte_mode  (byte_mode),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .sum        (sum),
    .lane_carry (lane_carry),
    .result     (result),
    .flags      (flags_next)
  );

  sff_flag_store u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd_en   (upd_en),
    .arith_in (flags_next),
    .ctl_wr   (ctl_wr),
    .ctl_in   (ctl_flags_t'(ctl_wdata)),
    .arith_q  (flags_q),
    .ctl_q    (ctl_q)
  );

  assign flag_word = pack_flags(flags_q, ctl_q);
endmodule

// File: rtl/sff_status_chk.sv
module sff_status_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_sel,
  input logic              byte_mode,
  input logic              upd_en,
  input logic              ctl_wr,
  input logic [2:0]        ctl_wdata,
  input logic [DATA_W-1:0] result,
  input logic [15:0]       flag_word
);
  localparam logic [15:0] COND_MASK = 16'h08D5;

  assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_word[1] && !flag_word[3] && !flag_word[5] && (flag_word[15:12] == 4'h0));

  assert_hold_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> ((flag_word & COND_MASK) == ($past(flag_word) & COND_MASK)));

  assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(flag_word[10:8]));

  assert_ctl_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (flag_word[10:8] == $past(ctl_wdata)));

  assert_logic_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel[2]) |=> (!flag_word[0] && !flag_word[4] && !flag_word[11]));

  assert_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (flag_word[2] == ~^$past(result[7:0])));

  assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (flag_word[6] == ($past(result) == '0)));

  assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (flag_word[7] ==
      ($past(byte_mode) ? $past(result[7]) : $past(result[DATA_W-1]))));

  assert_byte_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (result[DATA_W-1:8] == '0));
endmodule

bind sff_status_unit sff_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .op_sel    (op_sel),
  .byte_mode (byte_mode),
  .upd_en    (upd_en),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .result    (result),
  .flag_word (flag_word)
);

// File: tb/sff_status_unit_bench.sv
module sff_status_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_sel;
  logic        byte_mode;
  logic [15:0] opnd_a, opnd_b;
  logic        carry_in, upd_en, ctl_wr;
  logic [2:0]  ctl_wdata;
  logic [15:0] result, flag_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [2:0] ctl_exp = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;

  sff_status_unit u_sff_status_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .byte_mode(byte_mode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .upd_en(upd_en),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .result(result), .flag_word(flag_word)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (op=%0d byte=%0b a=%h b=%h ci=%0b)",
               tag, act, exp, op_sel, byte_mode, opnd_a, opnd_b, carry_in);
    end
  endtask

  // Expected result and flags from the requirement text.
  task automatic model(input int op, input bit bm, input int a, input int b, input bit ci,
                       output int r, output bit cf, output bit pf, output bit af,
                       output bit zf, output bit sf, output bit of);
    int m, half, ua, ub, c, sa, sb, t, s;
    m    = bm ? 255 : 65535;
    half = (m + 1) / 2;
    ua   = a & m;
    ub   = b & m;
    c    = (op == 1 || op == 3) ? int'(ci) : 0;
    sa   = (ua >= half) ? ua - (m + 1) : ua;
    sb   = (ub >= half) ? ub - (m + 1) : ub;
    cf = 0; af = 0; of = 0;
    case (op)
      0, 1: begin
        s  = ua + ub + c;
        cf = s > m;
        af = ((ua & 15) + (ub & 15) + c) > 15;
        t  = sa + sb + c;
        of = (t > half - 1) || (t < -half);
        r  = s & m;
      end
      2, 3: begin
        s  = ua - ub - c;
        cf = ua < ub + c;
        af = (ua & 15) < (ub & 15) + c;
        t  = sa - sb - c;
        of = (t > half - 1) || (t < -half);
        r  = s & m;
      end
      4: r = ua & ub;
      5: r = ua | ub;
      6: r = ua ^ ub;
      default: r = ub;
    endcase
    pf = ~^(r[7:0]);
    zf = (r == 0);
    sf = bm ? r[7] : r[15];
  endtask

  task automatic run_vec(input int op, input bit bm, input int a, input int b, input bit ci);
    int r; bit cf, pf, af, zf, sf, of;
    model(op, bm, a, b, ci, r, cf, pf, af, zf, sf, of);
    @(negedge clk);
    op_sel = 3'(op); byte_mode = bm; opnd_a = 16'(a); opnd_b = 16'(b);
    carry_in = ci; upd_en = 1'b1; ctl_wr = 1'b0;
    #1 chk("R1 result", result, 16'(r));
    @(posedge clk);
    #1;
    chk("R2 carry", {15'b0, flag_word[0]}, {15'b0, cf});
    chk("R3 parity", {15'b0, flag_word[2]}, {15'b0, pf});
    chk("R4 nibble carry", {15'b0, flag_word[4]}, {15'b0, af});
    chk("R5 zero/sign", {14'b0, flag_word[7:6]}, {14'b0, sf, zf});
    chk("R6 overflow", {15'b0, flag_word[11]}, {15'b0, of});
    chk("R9 control kept", {13'b0, flag_word[10:8]}, {13'b0, ctl_exp});
  endtask

  function automatic int val8(input int i);
    case (i)
      0: return 0;
      1: return 'h7F;
      2: return 'h80;
      3: return 'hFF;
      4: return 'h0F;
      5: return 'h10;
      default: return (i * 8 + (i & 7)) & 255;
    endcase
  endfunction

  function automatic int val16(input int i);
    case (i)
      0: return 0;
      1: return 'h7FFF;
      2: return 'h8000;
      3: return 'hFFFF;
      4: return 'h00FF;
      5: return 'h0100;
      6: return 'h0FFF;
      7: return 'h1000;
      default: return (i * 2731 + (i << 10)) & 'hFFFF;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; op_sel = 3'd0; byte_mode = 1'b0; opnd_a = '0; opnd_b = '0;
    carry_in = 1'b0; upd_en = 1'b0; ctl_wr = 1'b0; ctl_wdata = 3'b000;
    repeat (3) @(posedge clk);
    #1 chk("R10 reset value", flag_word, 16'h0002);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R10 after release", flag_word, 16'h0002);

    // R2: byte add 0x71 + 0x99 carries out of bit 7
    run_vec(0, 1'b1, 'h71, 'h99, 1'b0);
    chk("R2 0x71+0x99 byte", flag_word & 16'h0001, 16'h0001);

    // R7: carry_in ignored for plain add
    run_vec(0, 1'b0, 'h1234, 'h0001, 1'b1);
    chk("R7 add ignores carry_in", result, 16'h1235);

    // R9: control write, then arithmetic leaves it alone
    @(negedge clk);
    upd_en = 1'b0; ctl_wr = 1'b1; ctl_wdata = 3'b101;
    @(posedge clk); #1;
    ctl_exp = 3'b101;
    chk("R9 control load", {13'b0, flag_word[10:8]}, 16'h0005);
    run_vec(2, 1'b0, 0, 1, 1'b0);
    chk("R9 control after update", {13'b0, flag_word[10:8]}, 16'h0005);

    // R8: hold with upd_en low while inputs change
    held = flag_word;
    @(negedge clk);
    upd_en = 1'b0; ctl_wr = 1'b0; op_sel = 3'd4; opnd_a = '0; opnd_b = '0;
    @(posedge clk); #1;
    chk("R8 hold with update low", flag_word, held);
    chk("R10 fixed bits", flag_word & 16'hF02A, 16'h0002);

    // R6 corner: byte 0 - 0x7F - 1 is -128, no overflow; 0x80 - 1 overflows
    run_vec(3, 1'b1, 0, 'h7F, 1'b1);
    chk("R6 sbb boundary no ovf", {15'b0, flag_word[11]}, 16'h0000);
    run_vec(2, 1'b1, 'h80, 1, 1'b0);
    chk("R6 sub overflow", {15'b0, flag_word[11]}, 16'h0001);

    // Sweep: byte mode
    for (int ia = 0; ia < 32; ia++)
      for (int ib = 0; ib < 32; ib++)
        for (int op = 0; op < 8; op++)
          for (int ci = 0; ci < 2; ci++)
            run_vec(op, 1'b1, val8(ia) | (ib << 8), val8(ib) | (ia << 9), ci[0]);

    @(negedge clk);
    upd_en = 1'b0; ctl_wr = 1'b1; ctl_wdata = 3'b010;
    @(posedge clk); #1;
    ctl_exp = 3'b010;
    chk("R9 control reload", {13'b0, flag_word[10:8]}, 16'h0002);

    // Sweep: word mode
    for (int ia = 0; ia < 64; ia++)
      for (int ib = 0; ib < 64; ib++)
        for (int op = 0; op < 8; op++)
          for (int ci = 0; ci < 2; ci++)
            run_vec(op, 1'b0, val16(ia), val16(ib), ci[0]);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule